// File: doc/BRIEF.md
# Dual-Channel Stochastic Event-Rate Monitor

This block estimates, for two channels at once, the fraction of sampled events that are hits. Each channel picks one of five event sources from a small control register. Every source is a pair of signals: a sample strobe and a hit bit. On each strobe of its chosen source, a channel updates an 8-bit estimate. The estimate reads as a probability once it is divided by 255. No counter in the block can overflow and nothing raises an interrupt. The estimate simply tracks the recent hit rate.

Each channel holds an up/down integrator. On every accepted sample, the integrator is compared with a pseudo-random byte. The result of that comparison is XORed with the hit bit. When the two bits disagree, the integrator steps one count toward the hit bit. When they agree, it holds. In the long run this drives the integrator toward the hit probability times 255.

Each channel also has a sample counter. It shows how many samples have arrived since the control register was last written, and a valid flag rises once enough samples have been seen. A synchronous soft reset restarts the estimates but keeps the selection.

Top module: `evmon_top`

## Requirements
- R1: On a sample accepted by a channel, let G be 1 when the estimate is greater than or equal to the random byte. When G differs from the hit bit, the estimate moves one count: up if the hit is 1, down if the hit is 0. When G equals the hit bit, the estimate holds. With every sample a hit, the estimate rises above 0xE0 within 3000 samples.
- R2: The estimate saturates at 0x00 and at 0xFF and never wraps.
- R3: The random byte comes from a 31-stage shift register. Its bit 0 takes bit 30 XOR bit 2, and the other bits shift up by one. The register is seeded with 1 at either reset. It shifts only in cycles where at least one channel accepts a sample. The random byte is the inverse of bit 30, followed by bits 29 down to 23.
- R4: After power-on reset, both estimates read 0x80, both sample counts read 0, both valid flags read 0, and the control register reads 0x00.
- R5: The control register holds channel 0's select in bits [2:0] and channel 1's select in bits [6:4]. Bits 3 and 7 read as 0. A write takes effect in the next cycle.
- R6: Select code k, for k from 1 to 5, makes the channel follow source index k-1 (`src_stb[k-1]` and `src_hit[k-1]`). Index 0 is page/bank miss, 1 is write-buffer hit, 2 is read merge, 3 is write-buffer full and 4 is read-buffer hit. Strobes on other sources have no effect on that channel.
- R7: Select codes 0, 6 and 7 disable a channel. Its estimate freezes, its sample count does not advance, and its source's strobes do not shift the random register.
- R8: A soft reset sets both estimates to 0x80 and both sample counts to 0, and reseeds the random register. The control register keeps its value.
- R9: The sample count rises by one for each accepted sample and saturates at 4095. Any write to the control register clears both sample counts, and the clear wins over a sample in the same cycle.
- R10: The valid flag of a channel is 1 exactly when its sample count is 500 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous soft reset; clears estimates and counts, keeps the selection |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| src_stb | input | 5 | Sample strobe for each event source |
| src_hit | input | 5 | Hit bit for each event source, valid with its strobe |
| rate0 | output | 8 | Channel 0 estimate (value/255 = probability) |
| rate1 | output | 8 | Channel 1 estimate |
| nsamp0 | output | 12 | Channel 0 samples since the last control write |
| nsamp1 | output | 12 | Channel 1 samples since the last control write |
| valid0 | output | 1 | Channel 0 has seen enough samples |
| valid1 | output | 1 | Channel 1 has seen enough samples |

## Verification
Some properties are checked on every cycle. An estimate moves at most one count per cycle and never jumps between 0x00 and 0xFF. A hit never lowers it. It stays put in any cycle without an accepted sample. The random register never holds zero. A control write or soft reset leaves the sample counts at zero. A soft reset brings both estimates back to 0x80 and leaves the selection untouched.

Other behaviour shows only in the bench's scenarios, which compare exact values against a model written from the requirements. These include the mapping of codes to sources and the exact sequence of random numbers, which proves that disabled strobes do not shift the register. They also include convergence toward the hit rate under fixed, alternating and one-in-four hit patterns. The bench also covers saturation of the sample count and the edge of the valid flag at 499 and 500 samples.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int unsigned NCHAN   = 2;              // estimator channels
  localparam int unsigned NSRC    = 5;              // steerable event sources
  localparam int unsigned SEL_W   = 3;              // select field width
  localparam int unsigned FIELD_W = SEL_W + 1;      // select plus one reserved bit
  localparam int unsigned CTL_W   = NCHAN * FIELD_W;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/evmon_lfsr.sv
module evmon_lfsr #(
  parameter int unsigned      W     = 31,
  parameter int unsigned      TAP   = 3,
  parameter int unsigned      OUT_W = 8,
  parameter logic [W-1:0]     SEED  = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reseed,
  input  logic             adv,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv)    st_d = {st_q[W-2:0], st_q[W-1] ^ st_q[TAP-1]};
    if (reseed) st_d = SEED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  // top bits, most significant one inverted
  assign rnd = {~st_q[W-1], st_q[W-2:W-OUT_W]};

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R3

  AST_LFSR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !reseed) |=> $stable(rnd)); // R3
endmodule

// File: rtl/evmon_chan.sv
module evmon_chan #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SCNT_W    = 12,
  parameter int unsigned VALID_MIN = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              smp_stb,
  input  logic              smp_hit,
  input  logic [CNT_W-1:0]  rnd,
  input  logic              samp_clr,
  output logic [CNT_W-1:0]  rate,
  output logic [SCNT_W-1:0] nsamp,
  output logic              valid
);
  localparam logic [CNT_W-1:0]  MID  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0]  MAXC = '1;
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
  localparam logic [SCNT_W-1:0] NMAX = '1;
  localparam logic [SCNT_W-1:0] VMIN = SCNT_W'(VALID_MIN);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SCNT_W-1:0] n_q, n_d;
  logic              ge;

  assign ge = (cnt_q >= rnd);

  always_comb begin
    cnt_d = cnt_q;
    if (smp_stb && (ge ^ smp_hit)) begin
      if (smp_hit && (cnt_q != MAXC))      cnt_d = cnt_q + ONE;
      else if (!smp_hit && (cnt_q != '0))  cnt_d = cnt_q - ONE;
    end
    if (soft_rst) cnt_d = MID;
  end

  always_comb begin
    n_d = n_q;
    if (smp_stb && (n_q != NMAX)) n_d = n_q + SCNT_W'(1);
    if (samp_clr || soft_rst)     n_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= MID;
      n_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
    end
  end

  assign rate  = cnt_q;
  assign nsamp = n_q;
  assign valid = (n_q >= VMIN);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !soft_rst) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE)); // R1

  AST_HIT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && smp_hit && !soft_rst) |=> (cnt_q >= $past(cnt_q))); // R1

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> !(($past(cnt_q) == '0 && cnt_q == MAXC) ||
                    ($past(cnt_q) == MAXC && cnt_q == '0))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !soft_rst) |=> $stable(cnt_q)); // R7

  AST_SAMP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_clr || soft_rst) |=> (nsamp == '0)); // R9
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SCNT_W    = 12,
  parameter int unsigned VALID_MIN = 500,
  parameter int unsigned LFSR_W    = 31,
  parameter int unsigned LFSR_TAP  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic [NSRC-1:0]   src_stb,
  input  logic [NSRC-1:0]   src_hit,
  output logic [CNT_W-1:0]  rate0,
  output logic [CNT_W-1:0]  rate1,
  output logic [SCNT_W-1:0] nsamp0,
  output logic [SCNT_W-1:0] nsamp1,
  output logic              valid0,
  output logic              valid1
);
  localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);

  sel_t              sel_q  [NCHAN];
  sel_t              sel_d  [NCHAN];
  logic [NCHAN-1:0]  stb_m, hit_m;
  logic [CNT_W-1:0]  rnd;
  logic [CNT_W-1:0]  rate_w  [NCHAN];
  logic [SCNT_W-1:0] nsamp_w [NCHAN];
  logic [NCHAN-1:0]  valid_w;

  // control register: select fields only, reserved bits are not stored
  always_comb begin
    for (int c = 0; c < NCHAN; c++) begin
      sel_d[c] = sel_q[c];
      if (ctl_we) sel_d[c] = ctl_wdata[c*FIELD_W +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAN; c++) sel_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCHAN; c++) sel_q[c] <= sel_d[c];
    end
  end

  always_comb begin
    ctl_rdata = '0;
    for (int c = 0; c < NCHAN; c++) ctl_rdata[c*FIELD_W +: SEL_W] = sel_q[c];
  end

  // steering: code s+1 picks source s, any other code leaves the channel idle
  always_comb begin
    for (int c = 0; c < NCHAN; c++) begin
      stb_m[c] = 1'b0;
      hit_m[c] = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        if (sel_q[c] == SEL_W'(s + 1)) begin
          stb_m[c] = src_stb[s];
          hit_m[c] = src_hit[s];
        end
      end
    end
  end

  evmon_lfsr #(
    .W     (LFSR_W),
    .TAP   (LFSR_TAP),
    .OUT_W (CNT_W)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .reseed (soft_rst),
    .adv    (|stb_m),
    .rnd    (rnd)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    evmon_chan #(
      .CNT_W     (CNT_W),
      .SCNT_W    (SCNT_W),
      .VALID_MIN (VALID_MIN)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .smp_stb  (stb_m[c]),
      .smp_hit  (hit_m[c]),
      .rnd      (rnd),
      .samp_clr (ctl_we),
      .rate     (rate_w[c]),
      .nsamp    (nsamp_w[c]),
      .valid    (valid_w[c])
    );
  end

  assign rate0  = rate_w[0];
  assign rate1  = rate_w[1];
  assign nsamp0 = nsamp_w[0];
  assign nsamp1 = nsamp_w[1];
  assign valid0 = valid_w[0];
  assign valid1 = valid_w[1];

  AST_SOFT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rate0 == MID && rate1 == MID)); // R8

  AST_CTL_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !ctl_we) |=> $stable(ctl_rdata)); // R8

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata)); // R5
endmodule

// File: tb/test_evmon_top.sv
`timescale 1ns/1ps
module test_evmon_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [4:0]  src_stb = '0;
  logic [4:0]  src_hit = '0;
  logic [7:0]  rate0, rate1;
  logic [11:0] nsamp0, nsamp1;
  logic        valid0, valid1;

  int n_chk = 0;
  int n_fail = 0;
  int wd_cnt = 0;

  always #2 clk = ~clk;

  evmon_top i_evmon_top (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .src_stb(src_stb), .src_hit(src_hit),
    .rate0(rate0), .rate1(rate1), .nsamp0(nsamp0), .nsamp1(nsamp1),
    .valid0(valid0), .valid1(valid1)
  );

  // reference model built from the requirements
  logic [30:0] m_l = 31'd1;
  logic [7:0]  m_cnt [2] = '{8'h80, 8'h80};
  int          m_n   [2] = '{0, 0};
  logic [7:0]  m_ctl = 8'h00;

  task automatic model_step(input logic we, input logic [7:0] wd,
                            input logic [4:0] stb, input logic [4:0] hit,
                            input logic sr);
    logic [7:0] rnd;
    logic       any;
    logic [2:0] sel;
    logic       s, h, g;
    rnd = {~m_l[30], m_l[29:23]};
    any = 1'b0;
    for (int c = 0; c < 2; c++) begin
      sel = (c == 0) ? m_ctl[2:0] : m_ctl[6:4];
      s = 1'b0; h = 1'b0;
      if (sel >= 3'd1 && sel <= 3'd5) begin
        s = stb[sel - 3'd1];
        h = hit[sel - 3'd1];
      end
      if (s) begin
        any = 1'b1;
        g = (m_cnt[c] >= rnd);
        if (g != h) begin
          if (h && m_cnt[c] != 8'hFF)      m_cnt[c] = m_cnt[c] + 8'd1;
          else if (!h && m_cnt[c] != 8'h0) m_cnt[c] = m_cnt[c] - 8'd1;
        end
        if (m_n[c] < 4095) m_n[c] = m_n[c] + 1;
      end
      if (we || sr) m_n[c] = 0;
      if (sr) m_cnt[c] = 8'h80;
    end
    if (sr)       m_l = 31'd1;
    else if (any) m_l = {m_l[29:0], m_l[30] ^ m_l[2]};
    if (we) m_ctl = wd & 8'h77;
  endtask

  task automatic cyc(input logic we, input logic [7:0] wd,
                     input logic [4:0] stb, input logic [4:0] hit, input logic sr);
    ctl_we = we; ctl_wdata = wd; src_stb = stb; src_hit = hit; soft_rst = sr;
    model_step(we, wd, stb, hit, sr);
    @(negedge clk);
    ctl_we = 1'b0; src_stb = '0; src_hit = '0; soft_rst = 1'b0;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_model();
    chk("R5", "ctl_rdata", int'(ctl_rdata), int'(m_ctl));
    chk("R1", "rate0", int'(rate0), int'(m_cnt[0]));
    chk("R1", "rate1", int'(rate1), int'(m_cnt[1]));
    chk("R9", "nsamp0", int'(nsamp0), m_n[0]);
    chk("R9", "nsamp1", int'(nsamp1), m_n[1]);
    chk("R10", "valid0", int'(valid0), int'(m_n[0] >= 500));
    chk("R10", "valid1", int'(valid1), int'(m_n[1] >= 500));
  endtask

  // {we, wdata[7:0], stb[4:0], hit[4:0], mode[1:0], reps[15:0]}
  // mode 0: hits as given, 1: hits on odd cycles only, 2: hits every fourth cycle
  localparam int NV = 10;
  localparam logic [36:0] TBL [NV] = '{
    {1'b1, 8'h21, 5'h00, 5'h00, 2'd0, 16'd1},    // R6: ch0 page miss, ch1 wb hit
    {1'b0, 8'h00, 5'h1F, 5'h01, 2'd0, 16'd300},  // R1: ch0 climbs, ch1 falls
    {1'b0, 8'h00, 5'h1F, 5'h1F, 2'd1, 16'd400},  // R1: 50% pattern
    {1'b1, 8'h53, 5'h1F, 5'h04, 2'd2, 16'd600},  // R6: ch0 read merge 25%, ch1 read buffer
    {1'b1, 8'h06, 5'h1F, 5'h1F, 2'd0, 16'd200},  // R7: code 6 and code 0 freeze
    {1'b1, 8'hFF, 5'h1F, 5'h00, 2'd0, 16'd50},   // R5 R7: reserved bits dropped, code 7
    {1'b1, 8'h14, 5'h08, 5'h00, 2'd0, 16'd100},  // R6: ch0 wb full only
    {1'b0, 8'h00, 5'h01, 5'h01, 2'd0, 16'd3000}, // R2: ch1 toward top
    {1'b1, 8'h25, 5'h1F, 5'h00, 2'd0, 16'd3000}, // R2: both toward bottom
    {1'b1, 8'h12, 5'h03, 5'h03, 2'd1, 16'd700}   // R10: past 500 samples
  };

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000 cycles", wd_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [36:0] v;
    logic [4:0]  hv;
    logic [7:0]  r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state
    chk("R4", "rate0", int'(rate0), 8'h80);
    chk("R4", "rate1", int'(rate1), 8'h80);
    chk("R4", "nsamp0", int'(nsamp0), 0);
    chk("R4", "nsamp1", int'(nsamp1), 0);
    chk("R4", "valid0", int'(valid0), 0);
    chk("R4", "ctl_rdata", int'(ctl_rdata), 0);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      for (int k = 0; k < int'(v[15:0]); k++) begin
        hv = v[22:18];
        if (v[17:16] == 2'd1 && k[0] == 1'b0)   hv = '0;
        if (v[17:16] == 2'd2 && k[1:0] != 2'd0) hv = '0;
        cyc((k == 0) ? v[36] : 1'b0, v[35:28], v[27:23], hv, 1'b0);
      end
      chk_model();
    end

    // R5: reserved bits read zero after writing all ones
    cyc(1'b1, 8'hFF, 5'h00, 5'h00, 1'b0);
    chk("R5", "ctl reserved", int'(ctl_rdata), 8'h77);

    // R7: codes 0, 6 and 7 freeze estimate and count
    cyc(1'b1, 8'h11, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 100; k++) cyc(1'b0, 8'h00, 5'h1F, 5'h00, 1'b0);
    cyc(1'b1, 8'h60, 5'h00, 5'h00, 1'b0);
    r0 = rate0; r1 = rate1;
    for (int k = 0; k < 100; k++) cyc(1'b0, 8'h00, 5'h1F, 5'h1F, 1'b0);
    chk("R7", "rate0 frozen", int'(rate0), int'(r0));
    chk("R7", "rate1 frozen", int'(rate1), int'(r1));
    chk("R7", "nsamp0 idle", int'(nsamp0), 0);
    cyc(1'b1, 8'h07, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 50; k++) cyc(1'b0, 8'h00, 5'h1F, 5'h1F, 1'b0);
    chk("R7", "rate0 code7", int'(rate0), int'(r0));

    // R8: soft reset keeps selection
    cyc(1'b1, 8'h32, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 60; k++) cyc(1'b0, 8'h00, 5'h1F, 5'h1F, 1'b0);
    cyc(1'b0, 8'h00, 5'h00, 5'h00, 1'b1);
    chk("R8", "ctl kept", int'(ctl_rdata), 8'h32);
    chk("R8", "rate0", int'(rate0), 8'h80);
    chk("R8", "rate1", int'(rate1), 8'h80);
    chk("R8", "nsamp0", int'(nsamp0), 0);

    // R3: disabled strobes must not shift the random source
    cyc(1'b1, 8'h00, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 100; k++) cyc(1'b0, 8'h00, 5'h1F, 5'h1F, 1'b0);
    cyc(1'b1, 8'h11, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 80; k++) cyc(1'b0, 8'h00, 5'h01, {4'h0, k[0]}, 1'b0);
    chk("R3", "rate0 sequence", int'(rate0), int'(m_cnt[0]));
    chk("R3", "rate1 sequence", int'(rate1), int'(m_cnt[1]));

    // R6: each code follows only its own source
    for (int s = 0; s < 5; s++) begin
      cyc(1'b1, {5'h0, 3'(s + 1)}, 5'h00, 5'h00, 1'b0);
      for (int k = 0; k < 20; k++) cyc(1'b0, 8'h00, 5'(1 << s), 5'h1F, 1'b0);
      for (int k = 0; k < 20; k++) cyc(1'b0, 8'h00, ~5'(1 << s), 5'h1F, 1'b0);
      chk("R6", "nsamp0 own source", int'(nsamp0), 20);
    end

    // R1 R2: convergence and saturation
    cyc(1'b0, 8'h00, 5'h00, 5'h00, 1'b1);
    cyc(1'b1, 8'h11, 5'h00, 5'h00, 1'b0);
    for (int k = 0; k < 3000; k++) cyc(1'b0, 8'h00, 5'h01, 5'h01, 1'b0);
    chk("R1", "rate0 above 0xE0", int'(rate0 > 8'hE0), 1);
    for (int k = 0; k < 2000; k++) cyc(1'b0, 8'h00, 5'h01, 5'h01, 1'b0);
    chk("R2", "rate0 top", int'(rate0), int'(m_cnt[0]));
    for (int k = 0; k < 6000; k++) cyc(1'b0, 8'h00, 5'h01, 5'h00, 1'b0);
    chk("R2", "rate0 bottom", int'(rate0), int'(m_cnt[0]));
    chk("R2", "rate0 not wrapped", int'(rate0 < 8'h20), 1);

    // R9: count saturation
    chk("R9", "nsamp0 saturated", int'(nsamp0), 4095);
    chk("R9", "nsamp1 saturated", int'(nsamp1), 4095);

    // R9: clear wins over a sample in the write cycle
    cyc(1'b1, 8'h11, 5'h01, 5'h01, 1'b0);
    chk("R9", "nsamp0 clear wins", int'(nsamp0), 0);

    // R10: valid edge
    for (int k = 0; k < 499; k++) cyc(1'b0, 8'h00, 5'h01, 5'h00, 1'b0);
    chk("R10", "valid0 at 499", int'(valid0), 0);
    cyc(1'b0, 8'h00, 5'h01, 5'h00, 1'b0);
    chk("R10", "valid0 at 500", int'(valid0), 1);
    chk_model();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule